// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register bank of a system clock controller. It sits behind a plain 32-bit register bus made of a byte address, a write strobe with write data, and a read strobe with registered read data. The bank holds the PLL control words, the CPU and peripheral bus divider settings, the memory configuration words, the PLL settle-time, bias and tuning words. Every one of these has a fixed value after reset. No PLL, divider or clock gate is built here. The bank returns the register images that software expects to see.

Three behaviours go beyond plain storage. A PLL control word written with its enable bit set reads back as locked straight away. The update request bit of the DRAM configuration word never stays set. Accesses past the end of the register map do no harm: reads return zero, writes are dropped, and both raise a one-cycle error pulse. A separate one-cycle pulse marks writes to in-map words that need no special handling.

Top module: `clkctl_regbank`

## Requirements
- R1: After a synchronous active-high reset, each word reads back its fixed value. PLL controls at byte 0x000 and 0x020 hold 0x00001000, and 0x008 holds 0x00035514. 0x010, 0x018, 0x038 and 0x048 hold 0x03006207, and 0x028 and 0x044 hold 0x00041811. 0x050 holds 0x00010000, 0x054 holds 0x00001010, 0x058 holds 0x01000000, 0x0F4 holds 0, 0x0FC holds 0x80000000, and 0x200 and 0x204 hold 0x000000FF. Among the bias words, 0x220 holds 0x08100200, 0x230 holds 0x81104000, and 0x234 and 0x244 hold 0x10100010. 0x224, 0x228, 0x22C, 0x23C and 0x248 hold 0x10100000. The tuning words hold 0x0A101000 at 0x250 and 0x14880000 at 0x260. Every other in-map word holds 0.
- R2: Every access is one 32-bit word at word index address[9:2]. Address bits [1:0] have no effect.
- R3: Read data appears on rd_data at the clock edge that samples rd_en. It then holds until the next read.
- R4: A write to a PLL control word (byte 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x038, 0x044 or 0x048) with bit 31 set stores the value with bit 28 forced to 1. With bit 31 clear, the value is stored unchanged.
- R5: A write to the DRAM configuration word (0x0F4) stores the value with bit 16 forced to 0.
- R6: A write to any other in-map word (byte offset below 0x308) stores the value unchanged and pulses unimpl_wr high for exactly one cycle after the write.
- R7: A read at byte offset 0x308 or above returns 0 and pulses bus_err high for one cycle.
- R8: A write at byte offset 0x308 or above changes no stored word, pulses bus_err for one cycle and does not pulse unimpl_wr.
- R9: A read and a write to the same word in the same cycle return the value held before the write.
- R10: Writes to PLL control or DRAM configuration words do not pulse unimpl_wr. An idle cycle leaves both pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 10 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access beyond the map |
| unimpl_wr | output | 1 | One-cycle pulse after a plain in-map write |

## Verification
The assertions assume that a read and a write in the same cycle target the same word when both are used, and that the strobes are never unknown once reset is released. The stimulus raises at most one strobe per cycle, except in the one same-word read-and-write test. It drives every input on the falling edge and returns the strobes to zero between accesses, so each pulse can be seen on its own.

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
  parameter int ADDR_W  = 10,
  parameter int MAP_END = 'h308
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              bus_err,
  output logic              unimpl_wr
);

  localparam int NWORDS  = MAP_END / 4;
  localparam int IW      = $clog2(NWORDS);
  localparam int DRAM_W  = 'h0F4;
  localparam int EN_BIT  = 31;
  localparam int LK_BIT  = 28;
  localparam int UPD_BIT = 16;

  function automatic logic [31:0] init_word(input int off);
    case (off)
      'h000, 'h020:                      init_word = 32'h0000_1000;
      'h008:                             init_word = 32'h0003_5514;
      'h010, 'h018, 'h038, 'h048:        init_word = 32'h0300_6207;
      'h028, 'h044:                      init_word = 32'h0004_1811;
      'h050:                             init_word = 32'h0001_0000;
      'h054:                             init_word = 32'h0000_1010;
      'h058:                             init_word = 32'h0100_0000;
      'h0FC:                             init_word = 32'h8000_0000;
      'h200, 'h204:                      init_word = 32'h0000_00FF;
      'h220:                             init_word = 32'h0810_0200;
      'h230:                             init_word = 32'h8110_4000;
      'h234, 'h244:                      init_word = 32'h1010_0010;
      'h224, 'h228, 'h22C, 'h23C, 'h248: init_word = 32'h1010_0000;
      'h250:                             init_word = 32'h0A10_1000;
      'h260:                             init_word = 32'h1488_0000;
      default:                           init_word = 32'h0;
    endcase
  endfunction

  function automatic logic pll_word(input int off);
    case (off)
      'h000, 'h008, 'h010, 'h018, 'h020,
      'h028, 'h038, 'h044, 'h048: pll_word = 1'b1;
      default:                    pll_word = 1'b0;
    endcase
  endfunction

  logic [31:0]       regs [NWORDS];
  logic [ADDR_W-3:0] widx;
  logic [ADDR_W-1:0] woff;
  logic [IW-1:0]     sidx;
  logic              in_map, is_pll, is_dram;
  logic [31:0]       wval;
  logic              unused_lo;

  assign widx      = addr[ADDR_W-1:2];
  assign woff      = {widx, 2'b00};
  assign unused_lo = ^addr[1:0];
  assign in_map    = 32'(widx) < NWORDS;
  assign sidx      = IW'(widx);
  assign is_pll    = pll_word(32'(woff));
  assign is_dram   = 32'(woff) == DRAM_W;

  always_comb begin
    wval = wr_data;
    if (is_pll && wr_data[EN_BIT]) wval[LK_BIT] = 1'b1;
    if (is_dram) wval[UPD_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) regs[i] <= init_word(i * 4);
      rd_data   <= '0;
      bus_err   <= 1'b0;
      unimpl_wr <= 1'b0;
    end else begin
      bus_err   <= (wr_en || rd_en) && !in_map;
      unimpl_wr <= wr_en && in_map && !is_pll && !is_dram;
      if (rd_en) rd_data <= in_map ? regs[sidx] : '0;
      if (wr_en && in_map) regs[sidx] <= wval;
    end
  end

  p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en && !in_map |=> rd_data == '0);
  p_oob_read_err_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en && !in_map |=> bus_err);
  p_oob_write_err_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en && !in_map |=> bus_err && !unimpl_wr);
  p_lock_set_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en && in_map && is_pll && wr_data[EN_BIT] |=> regs[$past(sidx)][LK_BIT]);
  p_dram_upd_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en && is_dram |=> !rd_data[UPD_BIT]);
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  p_plain_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en && in_map && !is_pll && !is_dram |=> unimpl_wr);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !rd_en |=> !bus_err && !unimpl_wr);

endmodule

// File: tb/clkctl_regbank_test.sv
`timescale 1ns/1ps
module clkctl_regbank_test;
  logic clk = 0, rst = 1;
  logic [9:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic bus_err, unimpl_wr;
  int checks = 0, fails = 0;
  logic done = 0;

  always #4 clk = ~clk;

  clkctl_regbank uut (.clk, .rst, .addr, .wr_en, .wr_data, .rd_en,
                      .rd_data, .bus_err, .unimpl_wr);

  // R1 reset table: {byte offset, value}
  localparam logic [41:0] RST_TAB [30] = '{
    {10'h000, 32'h00001000}, {10'h008, 32'h00035514}, {10'h010, 32'h03006207},
    {10'h018, 32'h03006207}, {10'h020, 32'h00001000}, {10'h028, 32'h00041811},
    {10'h038, 32'h03006207}, {10'h044, 32'h00041811}, {10'h048, 32'h03006207},
    {10'h050, 32'h00010000}, {10'h054, 32'h00001010}, {10'h058, 32'h01000000},
    {10'h0F4, 32'h00000000}, {10'h0FC, 32'h80000000}, {10'h200, 32'h000000FF},
    {10'h204, 32'h000000FF}, {10'h220, 32'h08100200}, {10'h224, 32'h10100000},
    {10'h228, 32'h10100000}, {10'h22C, 32'h10100000}, {10'h230, 32'h81104000},
    {10'h234, 32'h10100010}, {10'h23C, 32'h10100000}, {10'h244, 32'h10100010},
    {10'h248, 32'h10100000}, {10'h250, 32'h0A101000}, {10'h260, 32'h14880000},
    {10'h004, 32'h00000000}, {10'h100, 32'h00000000}, {10'h304, 32'h00000000}};

  // write vectors: {offset, write, expected readback, expected unimpl pulse}
  localparam logic [74:0] WR_TAB [10] = '{
    {10'h000, 32'h80000000, 32'h90000000, 1'b0},  // R4 enable -> lock
    {10'h010, 32'h00001234, 32'h00001234, 1'b0},  // R4 enable clear
    {10'h044, 32'h10000055, 32'h10000055, 1'b0},  // R4 lock written, no enable
    {10'h048, 32'hEFFFFFFF, 32'hFFFFFFFF, 1'b0},  // R4
    {10'h0F4, 32'hFFFFFFFF, 32'hFFFEFFFF, 1'b0},  // R5
    {10'h0F4, 32'h00010001, 32'h00000001, 1'b0},  // R5
    {10'h054, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1},  // R6
    {10'h250, 32'h90010000, 32'h90010000, 1'b1},  // R6 no lock/update rule
    {10'h300, 32'h12345678, 32'h12345678, 1'b1},  // R6 unmapped in-map
    {10'h304, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b1}}; // R6 last word

  task automatic chk(input logic ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] q);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; q = rd_data;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, keep;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(rd_data == 0 && !bus_err && !unimpl_wr, "R1 reset outputs", rd_data, 0);

    for (int i = 0; i < 30; i++) begin
      rd(RST_TAB[i][41:32], q);
      chk(q == RST_TAB[i][31:0], "R1 reset value", q, RST_TAB[i][31:0]);
    end

    for (int i = 0; i < 10; i++) begin
      wr(WR_TAB[i][74:65], WR_TAB[i][64:33]);
      chk(unimpl_wr == WR_TAB[i][0], "R6/R10 unimpl pulse", 32'(unimpl_wr), 32'(WR_TAB[i][0]));
      chk(!bus_err, "R10 no error on in-map write", 32'(bus_err), 0);
      @(negedge clk);
      chk(!unimpl_wr && !bus_err, "R10 idle quiet", {unimpl_wr, bus_err}, 0);
      rd(WR_TAB[i][74:65], q);
      chk(q == WR_TAB[i][32:1], "R4/R5/R6 readback", q, WR_TAB[i][32:1]);
    end

    // R2 low address bits ignored
    rd(10'h003, q);
    chk(q == 32'h90000000, "R2 low bits", q, 32'h90000000);
    wr(10'h05A, 32'h0000C0DE);
    rd(10'h058, q);
    chk(q == 32'h0000C0DE, "R2 low bits write", q, 32'h0000C0DE);

    // R3 hold
    keep = rd_data;
    repeat (3) @(negedge clk);
    chk(rd_data == keep, "R3 hold", rd_data, keep);

    // R7 out-of-range reads
    rd(10'h308, q);
    chk(q == 0 && bus_err, "R7 read 0x308", q, 0);
    @(negedge clk);
    chk(!bus_err, "R7 single pulse", 32'(bus_err), 0);
    rd(10'h3FC, q);
    chk(q == 0 && bus_err, "R7 read 0x3FC", q, 0);

    // R8 out-of-range write discarded
    wr(10'h308, 32'hFFFFFFFF);
    chk(bus_err && !unimpl_wr, "R8 write pulse", {bus_err, unimpl_wr}, 2);
    rd(10'h308, q);
    chk(q == 0, "R8 nothing stored", q, 0);
    rd(10'h304, q);
    chk(q == 32'hA5A5A5A5, "R8 neighbour intact", q, 32'hA5A5A5A5);
    wr(10'h3C8, 32'h11111111);
    rd(10'h0C8, q);
    chk(q == 0, "R8 no aliasing", q, 0);

    // R9 simultaneous read and write
    @(negedge clk); addr = 10'h200; wr_data = 32'h00000042; wr_en = 1; rd_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk(rd_data == 32'h000000FF, "R9 old value", rd_data, 32'h000000FF);
    rd(10'h200, q);
    chk(q == 32'h00000042, "R9 new value", q, 32'h00000042);

    // R1 reset reapplied
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(10'h000, q);
    chk(q == 32'h00001000, "R1 reset restores", q, 32'h00001000);
    rd(10'h300, q);
    chk(q == 0, "R1 reset clears in-map word", q, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule